// File: doc/BRIEF.md
# Data-Space Decoder with External Memory Sequencer

This block sits between a CPU load/store unit and the data memories of a small controller. It sorts each 16-bit data address into one region: register file, standard I/O, extended I/O, internal SRAM, or external SRAM. Accesses to the first four regions finish in the same cycle: the block raises a one-hot select towards the matching array and never stalls the core.

An address beyond the internal SRAM goes to external memory. If the external enable is set, the block starts a short bus cycle. The cycle drives a registered address, write data and one active-low strobe, and it holds a stall towards the core until the cycle is over. A wait-state input of 0 to 3 lengthens that cycle.

A layout input chooses between two maps. The normal map has an extended I/O window and a larger internal region. The compatibility map has no extended I/O, so the external boundary is lower. If the external enable is clear, an external address completes at once, with no bus activity, and a read returns zero.

Top module: `dspace_xmem_ctrl`

## Requirements
- R1: With `cfg_compat`=0 and `req_valid`=1, `sel` is one-hot with this bit encoding: bit0 for addresses 0x0000-0x001F (register file), bit1 for 0x0020-0x005F (standard I/O), bit2 for 0x0060-0x00FF (extended I/O), and bit3 for 0x0100-0x10FF (internal SRAM). `sel` is zero when `req_valid`=0.
- R2: With `cfg_compat`=1, bits 0 and 1 decode as in R1. Addresses 0x0060-0x0FFF raise bit3. Bit2 is never raised.
- R3: Addresses at or above 0x1100 (normal map) or 0x1000 (compatibility map) are external, and `sel` stays zero for them.
- R4: An internal access never raises `stall`, and both `xbus_rd_n` and `xbus_wr_n` stay high during it.
- R5: For an enabled external access with wait-state value W (`cfg_wait`, 0..3), `stall` is high in the request cycle and the W cycles after it, then low for one final cycle. The access therefore takes W+1 cycles more than an internal one.
- R6: From the cycle after the request through the final cycle, exactly one strobe is low: `xbus_rd_n` for reads, `xbus_wr_n` for writes. Both strobes are high at every other time.
- R7: While `xbus_wr_n` is low, `xbus_addr` equals the request address and `xbus_dout` equals the write data, and neither changes between consecutive cycles.
- R8: An enabled external read samples `xbus_din` in its final cycle and presents the value on `rd_data` from the next cycle until the next read completes.
- R9: With `cfg_xen`=0, an external access raises neither `stall` nor any strobe. An external read then loads zero into `rd_data` for the next cycle.
- R10: After reset, `stall` is low, both strobes are high and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_compat | input | 1 | 1 selects the compatibility map without extended I/O |
| cfg_xen | input | 1 | External memory enable |
| cfg_wait | input | 2 | Wait states added to external cycles (0..3) |
| req_valid | input | 1 | Access request, held by the core while `stall` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space address |
| req_wdata | input | 8 | Write data |
| sel | output | 4 | One-hot internal region select (R1 encoding) |
| stall | output | 1 | Core must hold the request |
| rd_data | output | 8 | Result of the last external read |
| xbus_addr | output | 16 | External address |
| xbus_dout | output | 8 | External write data |
| xbus_din | input | 8 | External read data |
| xbus_rd_n | output | 1 | External read strobe, active low |
| xbus_wr_n | output | 1 | External write strobe, active low |

## Verification
A wrong layout decision appears in the same cycle, as a wrong `sel` bit or a stall for an address that should be internal. A sequencer counter that is off by one shows up within four cycles, either as a stall that falls early or late or as a strobe that stays low too long. A bad capture register appears on `rd_data` one cycle after the final cycle. The bench therefore compares `stall`, `sel`, both strobes and the bus contents against a behavioural model in every cycle of every access, and checks `rd_data` after each access.

// File: rtl/dspace_pkg.sv
`timescale 1ns/1ps
package dspace_pkg;
   typedef enum logic [2:0] {
      RG_REGF  = 3'd0,
      RG_STDIO = 3'd1,
      RG_EXTIO = 3'd2,
      RG_ISRAM = 3'd3,
      RG_XMEM  = 3'd4
   } region_e;

   localparam int NUM_SEL = 4;
endpackage

// File: rtl/dspace_region_dec.sv
`timescale 1ns/1ps
module dspace_region_dec
   import dspace_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int RF_SIZE      = 32,
   parameter int IO_SIZE      = 64,
   parameter int XIO_SIZE     = 160,
   parameter int ISRAM_NORM   = 4096,
   parameter int ISRAM_COMPAT = 4000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              compat,
   output region_e           region
);
   localparam logic [31:0] RF_END     = 32'(RF_SIZE);
   localparam logic [31:0] IO_END     = 32'(RF_SIZE + IO_SIZE);
   localparam logic [31:0] XIO_END    = 32'(RF_SIZE + IO_SIZE + XIO_SIZE);
   localparam logic [31:0] SRAM_END_N = 32'(RF_SIZE + IO_SIZE + XIO_SIZE + ISRAM_NORM);
   localparam logic [31:0] SRAM_END_C = 32'(RF_SIZE + IO_SIZE + ISRAM_COMPAT);

   logic [31:0] a_ext;
   assign a_ext = {{(32-ADDR_W){1'b0}}, addr};

   generate
      if (XIO_SIZE > 0) begin : g_with_xio
         always_comb begin
            if (a_ext < RF_END)                     region = RG_REGF;
            else if (a_ext < IO_END)                region = RG_STDIO;
            else if (compat) begin
               if (a_ext < SRAM_END_C)              region = RG_ISRAM;
               else                                 region = RG_XMEM;
            end
            else if (a_ext < XIO_END)               region = RG_EXTIO;
            else if (a_ext < SRAM_END_N)            region = RG_ISRAM;
            else                                    region = RG_XMEM;
         end
      end else begin : g_no_xio
         always_comb begin
            if (a_ext < RF_END)                     region = RG_REGF;
            else if (a_ext < IO_END)                region = RG_STDIO;
            else if (a_ext < (compat ? SRAM_END_C : SRAM_END_N))
                                                    region = RG_ISRAM;
            else                                    region = RG_XMEM;
         end
      end
   endgenerate
endmodule

// File: rtl/xmem_seq.sv
`timescale 1ns/1ps
module xmem_seq #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int WS_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic [WS_W-1:0]   wait_cnt,
   output logic              busy,
   output logic              hold,
   output logic              fin_read,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_rd_n,
   output logic              bus_wr_n
);
   logic [WS_W-1:0] cnt_q;
   logic            we_q;
   logic            last;

   assign last     = busy && (cnt_q == '0);
   assign hold     = busy && (cnt_q != '0);
   assign fin_read = last && !we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt_q    <= '0;
         we_q     <= 1'b0;
         bus_addr <= '0;
         bus_dout <= '0;
         bus_rd_n <= 1'b1;
         bus_wr_n <= 1'b1;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            cnt_q    <= wait_cnt;
            we_q     <= start_we;
            bus_addr <= start_addr;
            bus_dout <= start_wdata;
            bus_rd_n <= start_we;
            bus_wr_n <= !start_we;
         end
      end else if (last) begin
         busy     <= 1'b0;
         bus_rd_n <= 1'b1;
         bus_wr_n <= 1'b1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/dspace_xmem_ctrl.sv
`timescale 1ns/1ps
module dspace_xmem_ctrl
   import dspace_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int WS_W         = 2,
   parameter int RF_SIZE      = 32,
   parameter int IO_SIZE      = 64,
   parameter int XIO_SIZE     = 160,
   parameter int ISRAM_NORM   = 4096,
   parameter int ISRAM_COMPAT = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_compat,
   input  logic              cfg_xen,
   input  logic [WS_W-1:0]   cfg_wait,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [NUM_SEL-1:0] sel,
   output logic              stall,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] xbus_addr,
   output logic [DATA_W-1:0] xbus_dout,
   input  logic [DATA_W-1:0] xbus_din,
   output logic              xbus_rd_n,
   output logic              xbus_wr_n
);
   localparam int MAP_TOP = RF_SIZE + IO_SIZE + XIO_SIZE + ISRAM_NORM;

   initial begin
      assert (ADDR_W >= 8 && ADDR_W < 32)
         else $error("ADDR_W out of range");
      assert (DATA_W >= 1)
         else $error("DATA_W must be positive");
      assert (WS_W >= 1 && WS_W <= 4)
         else $error("WS_W out of range");
      assert (MAP_TOP < (1 << ADDR_W))
         else $error("internal map does not fit the address space");
      assert (ISRAM_COMPAT <= XIO_SIZE + ISRAM_NORM)
         else $error("compatibility map larger than normal map");
   end

   region_e region;
   logic    is_xmem;
   logic    seq_busy;
   logic    seq_hold;
   logic    seq_fin_rd;
   logic    start;
   logic    off_read;

   dspace_region_dec #(
      .ADDR_W      (ADDR_W),
      .RF_SIZE     (RF_SIZE),
      .IO_SIZE     (IO_SIZE),
      .XIO_SIZE    (XIO_SIZE),
      .ISRAM_NORM  (ISRAM_NORM),
      .ISRAM_COMPAT(ISRAM_COMPAT)
   ) u_dec (
      .addr  (req_addr),
      .compat(cfg_compat),
      .region(region)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SEL; gi++) begin : g_sel
         assign sel[gi] = req_valid && (region == region_e'(3'(gi)));
      end
   endgenerate

   assign is_xmem  = req_valid && (region == RG_XMEM) && !seq_busy;
   assign start    = is_xmem && cfg_xen;
   assign off_read = is_xmem && !cfg_xen && !req_we;
   assign stall    = start || seq_hold;

   xmem_seq #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .WS_W  (WS_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_we   (req_we),
      .start_addr (req_addr),
      .start_wdata(req_wdata),
      .wait_cnt   (cfg_wait),
      .busy       (seq_busy),
      .hold       (seq_hold),
      .fin_read   (seq_fin_rd),
      .bus_addr   (xbus_addr),
      .bus_dout   (xbus_dout),
      .bus_rd_n   (xbus_rd_n),
      .bus_wr_n   (xbus_wr_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rd_data <= '0;
      else if (seq_fin_rd) rd_data <= xbus_din;
      else if (off_read)   rd_data <= '0;
   end
endmodule

// File: rtl/dspace_xmem_chk.sv
`timescale 1ns/1ps
module dspace_xmem_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int NSEL   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_xen,
   input logic [NSEL-1:0]   sel,
   input logic              stall,
   input logic [ADDR_W-1:0] xbus_addr,
   input logic [DATA_W-1:0] xbus_dout,
   input logic              xbus_rd_n,
   input logic              xbus_wr_n
);
   // R1
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!xbus_rd_n && !xbus_wr_n));

   // R4
   int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|sel) |-> (xbus_rd_n && xbus_wr_n && !stall));

   // R7
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xbus_wr_n && !$past(xbus_wr_n)) |-> ($stable(xbus_addr) && $stable(xbus_dout)));

   // R9
   xen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_xen && xbus_rd_n && xbus_wr_n) |-> !stall);

   // R5
   stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> (!xbus_rd_n || !xbus_wr_n));
endmodule

bind dspace_xmem_ctrl dspace_xmem_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .NSEL  (4)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_xen  (cfg_xen),
   .sel      (sel),
   .stall    (stall),
   .xbus_addr(xbus_addr),
   .xbus_dout(xbus_dout),
   .xbus_rd_n(xbus_rd_n),
   .xbus_wr_n(xbus_wr_n)
);

// File: tb/tb_dspace_xmem_ctrl.sv
`timescale 1ns/1ps
module tb_dspace_xmem_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_compat = 1'b0;
   logic        cfg_xen = 1'b0;
   logic [1:0]  cfg_wait = 2'd0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic [3:0]  sel;
   logic        stall;
   logic [7:0]  rd_data;
   logic [15:0] xbus_addr;
   logic [7:0]  xbus_dout;
   logic [7:0]  xbus_din;
   logic        xbus_rd_n;
   logic        xbus_wr_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] exp_rd = 8'h00;

   always #2 clk = ~clk;

   assign xbus_din = xbus_addr[7:0] ^ 8'hA5;

   dspace_xmem_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_compat(cfg_compat), .cfg_xen(cfg_xen),
      .cfg_wait(cfg_wait), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .sel(sel), .stall(stall),
      .rd_data(rd_data), .xbus_addr(xbus_addr), .xbus_dout(xbus_dout),
      .xbus_din(xbus_din), .xbus_rd_n(xbus_rd_n), .xbus_wr_n(xbus_wr_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // region code: 0 regfile, 1 std io, 2 ext io, 3 internal sram, 4 external
   function automatic int ref_region(input bit compat, input int a);
      if (a < 32) return 0;
      if (a < 96) return 1;
      if (compat) return (a < 4096) ? 3 : 4;
      if (a < 256) return 2;
      if (a < 4352) return 3;
      return 4;
   endfunction

   task automatic access(input bit compat, input bit xen, input int ws,
                         input bit we, input logic [15:0] a, input logic [7:0] wd);
      int rg;
      int n;
      logic [3:0] exp_sel;
      rg = ref_region(compat, int'(a));
      n  = (rg == 4 && xen) ? ws + 1 : 0;
      exp_sel = (rg < 4) ? 4'(1 << rg) : 4'h0;
      @(posedge clk); #1;
      cfg_compat = compat; cfg_xen = xen; cfg_wait = 2'(ws);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
      for (int k = 0; k <= n; k++) begin
         if (k > 0) begin @(posedge clk); #1; end
         @(negedge clk);
         chk(compat ? "R2 sel" : "R1 sel", 32'(sel), 32'(exp_sel));
         if (rg == 4) chk("R3 sel zero", 32'(sel), 0);
         if (rg < 4) chk("R4 stall", 32'(stall), 0);
         else if (!xen) chk("R9 stall", 32'(stall), 0);
         else chk("R5 stall", 32'(stall), (k < n) ? 1 : 0);
         chk("R6 rd_n", 32'(xbus_rd_n), (n > 0 && k >= 1 && !we) ? 0 : 1);
         chk("R6 wr_n", 32'(xbus_wr_n), (n > 0 && k >= 1 && we) ? 0 : 1);
         if (n > 0 && k >= 1) begin
            chk("R7 addr", 32'(xbus_addr), 32'(a));
            if (we) chk("R7 dout", 32'(xbus_dout), 32'(wd));
         end
      end
      if (rg == 4 && !we) exp_rd = xen ? (a[7:0] ^ 8'hA5) : 8'h00;
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      chk((rg == 4 && !xen) ? "R9 rd_data" : "R8 rd_data", 32'(rd_data), 32'(exp_rd));
      chk("R6 idle strobes", 32'({xbus_rd_n, xbus_wr_n}), 32'h3);
      chk("R5 idle stall", 32'(stall), 0);
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 stall", 32'(stall), 0);
      chk("R10 strobes", 32'({xbus_rd_n, xbus_wr_n}), 32'h3);
      chk("R10 rd_data", 32'(rd_data), 0);
      rst_n = 1'b1;
      // R1 normal map boundaries
      access(0, 1, 0, 0, 16'h001F, 8'h00);
      access(0, 1, 0, 1, 16'h0020, 8'h11);
      access(0, 1, 0, 0, 16'h005F, 8'h00);
      access(0, 1, 0, 0, 16'h0060, 8'h00);
      access(0, 1, 0, 1, 16'h00FF, 8'h22);
      access(0, 1, 0, 0, 16'h0100, 8'h00);
      access(0, 1, 3, 0, 16'h10FF, 8'h00);
      // R3 normal external boundary, all wait states
      access(0, 1, 0, 0, 16'h1100, 8'h00);
      access(0, 1, 1, 1, 16'h1234, 8'h5C);
      access(0, 1, 2, 0, 16'h8081, 8'h00);
      access(0, 1, 3, 1, 16'hFFFF, 8'hC3);
      access(0, 1, 3, 0, 16'hABCD, 8'h00);
      // R2 compatibility map
      access(1, 1, 0, 0, 16'h0060, 8'h00);
      access(1, 1, 0, 0, 16'h00FF, 8'h00);
      access(1, 1, 0, 1, 16'h0FFF, 8'h7E);
      access(1, 1, 2, 0, 16'h1000, 8'h00);
      access(1, 1, 1, 1, 16'h10FF, 8'h99);
      // R9 external enable clear
      access(0, 0, 3, 0, 16'h2000, 8'h00);
      access(0, 1, 0, 0, 16'h3033, 8'h00);
      access(1, 0, 2, 1, 16'h1000, 8'h44);
      access(1, 0, 1, 0, 16'h1001, 8'h00);
      // back-to-back external after disabled
      access(1, 1, 3, 0, 16'h4455, 8'h00);
      finish_run();
   end
endmodule